// File: doc/BRIEF.md
# Indirect CSR Access Exception Checker

This block decides, for one CSR access instruction per cycle, whether the access raises an illegal-instruction exception, a virtual-instruction exception, or neither. It covers the three indirect register windows (machine, supervisor and virtual-supervisor), which use the machine, supervisor and virtual-supervisor select registers. It also covers the supervisor interrupt-pending, interrupt-enable and timer-compare registers when a guest runs with the virtual-interrupt trap control set. The verdict appears on the output flags one clock after the inputs are presented.

The checker sits after a basic permission stage. That stage has already judged existence, write to read-only, privilege level and enable controls, and it hands its verdict in as two flags. Decisions come in two steps. First, the basic verdict and the interrupt-register rules are resolved, and the select value plays no part in them. Only if that step raises nothing is the select value of the accessed window classified into ranges. Each range yields an illegal or a virtual outcome, sometimes depending on the low bit of the select. An illegal outcome for the select always wins over a virtual outcome for the same access.

Top module: `icsr_excp_check`

## Requirements
- R1: When the basic-stage illegal flag is set, the next cycle shows illegal=1 and virtual=0, whatever else is applied.
- R2: When the basic-stage virtual flag is set and the basic illegal flag is clear, the next cycle shows virtual=1 and illegal=0, even if the select value would be illegal.
- R3: Machine window (id 1): illegal for a select of 0x2F or less, an odd select in 0x30..0x3F, any select in 0x40..0x6F, an odd select in 0x80..0xFF, or any select above 0xFF. Otherwise no exception.
- R4: Supervisor window (id 2) with virt=0: the R3 rules, applied to the supervisor select. In addition, the access is illegal in S mode (priv 1) when the external-interrupt-virtualization bit is set and the select is in 0x70..0xFF.
- R5: Supervisor window with virt=1: illegal when the virtual-supervisor select is 0x2F or less, in 0x40..0x6F, or above 0xFF.
- R6: Supervisor window with virt=1: virtual when that select is in 0x30..0x3F. It is also virtual when the select is in 0x70..0xFF and either the guest interrupt index is invalid (0 or greater than GEILEN) or the select is odd and above 0x7F.
- R7: Virtual-supervisor window (id 3): illegal for any select of 0x6F or less, or above 0xFF. In 0x70..0xFF it is illegal when the guest interrupt index is invalid or the select is odd and above 0x7F. This window never yields a virtual exception.
- R8: An access to interrupt-pending (id 4) or interrupt-enable (id 5) with virt=1, priv=1 and the trap control bit set is virtual.
- R9: A write to timer-compare (id 6) with virt=1, priv=1 and the trap control bit set is virtual. A read of it is not.
- R10: At most one output is high in any cycle. An access that matches no rule (including id 0 and id 7) yields neither output.
- R11: Outputs are registered. During reset both are 0, and each verdict appears one cycle after its inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| csr_id_i | input | 3 | Decoded CSR: 0 other, 1 machine window, 2 supervisor window, 3 virtual-supervisor window, 4 interrupt-pending, 5 interrupt-enable, 6 timer-compare |
| wr_i | input | 1 | Access writes the CSR |
| priv_i | input | 2 | Privilege: 0 user, 1 supervisor, 3 machine |
| virt_i | input | 1 | Virtualization active |
| msel_i | input | SEL_W | Machine select register |
| ssel_i | input | SEL_W | Supervisor select register |
| vssel_i | input | SEL_W | Virtual-supervisor select register |
| vgein_i | input | VG_W | Guest external interrupt index |
| seie_virt_i | input | 1 | Supervisor external interrupt virtualized by machine level |
| vti_i | input | 1 | Guest virtual-interrupt trap control |
| base_ill_i | input | 1 | Illegal verdict of the basic stage |
| base_virt_i | input | 1 | Virtual verdict of the basic stage |
| ill_o | output | 1 | Illegal-instruction exception |
| virt_o | output | 1 | Virtual-instruction exception |

## Verification
The assertions assume that the inputs are stable from one rising edge to the next. They also assume that priv_i never carries the encoding 2 together with a rule that depends on S mode. The bench drives every input on the falling edge, uses only the encodings 0, 1 and 3 for privilege, and samples on the following falling edge. The sweeps walk every select value from 0 to 0x1FF through each window and mode. The guest interrupt index is set to zero, to values inside GEILEN and to values just beyond it. The select registers that do not belong to the accessed window carry unrelated values, so that any use of the wrong select would be exposed.

// File: rtl/icsr_pkg.sv
package icsr_pkg;

    localparam logic [2:0] ID_OTHER = 3'd0;
    localparam logic [2:0] ID_MWIN  = 3'd1;
    localparam logic [2:0] ID_SWIN  = 3'd2;
    localparam logic [2:0] ID_VSWIN = 3'd3;
    localparam logic [2:0] ID_IPEND = 3'd4;
    localparam logic [2:0] ID_IENAB = 3'd5;
    localparam logic [2:0] ID_TCMP  = 3'd6;

    localparam logic [1:0] PRV_U = 2'd0;
    localparam logic [1:0] PRV_S = 2'd1;
    localparam logic [1:0] PRV_M = 2'd3;

    typedef enum logic [2:0] {
        SR_LOW,   // 0x000..0x02F
        SR_EXT,   // 0x030..0x03F
        SR_RSV,   // 0x040..0x06F
        SR_FLO,   // 0x070..0x07F
        SR_FHI,   // 0x080..0x0FF
        SR_OVR    // above 0x0FF
    } sel_reg_e;

    typedef struct packed {
        logic ill;
        logic virt;
    } excp_t;

    typedef struct packed {
        excp_t res;
        logic  armed;
    } chk_state_t;

endpackage

// File: rtl/icsr_sel_region.sv
module icsr_sel_region
    import icsr_pkg::*;
#(
    parameter int SEL_W = 12
) (
    input  logic [SEL_W-1:0] sel_i,
    output sel_reg_e         region_o,
    output logic             odd_o
);
    localparam logic [SEL_W-1:0] LOW_TOP = SEL_W'('h02F);
    localparam logic [SEL_W-1:0] EXT_TOP = SEL_W'('h03F);
    localparam logic [SEL_W-1:0] RSV_TOP = SEL_W'('h06F);
    localparam logic [SEL_W-1:0] FLO_TOP = SEL_W'('h07F);
    localparam logic [SEL_W-1:0] FHI_TOP = SEL_W'('h0FF);

    always_comb begin
        if (sel_i <= LOW_TOP)      region_o = SR_LOW;
        else if (sel_i <= EXT_TOP) region_o = SR_EXT;
        else if (sel_i <= RSV_TOP) region_o = SR_RSV;
        else if (sel_i <= FLO_TOP) region_o = SR_FLO;
        else if (sel_i <= FHI_TOP) region_o = SR_FHI;
        else                       region_o = SR_OVR;
    end

    assign odd_o = sel_i[0];
endmodule

// File: rtl/icsr_window_rules.sv
module icsr_window_rules
    import icsr_pkg::*;
#(
    parameter int GEILEN = 63,
    parameter int VG_W   = 6
) (
    input  logic [2:0]      csr_id_i,
    input  logic [1:0]      priv_i,
    input  logic            virt_i,
    input  logic            seie_virt_i,
    input  logic [VG_W-1:0] vgein_i,
    input  sel_reg_e        m_reg_i,
    input  logic            m_odd_i,
    input  sel_reg_e        s_reg_i,
    input  logic            s_odd_i,
    input  sel_reg_e        vs_reg_i,
    input  logic            vs_odd_i,
    output logic            ii_o,
    output logic            vi_o
);
    localparam logic [VG_W-1:0] GEI_MAX = VG_W'(GEILEN);

    logic vg_bad;
    logic m_base_ii, s_base_ii;
    logic s_file, vs_file, vs_file_bad;

    function automatic logic plain_ii(input sel_reg_e r, input logic odd);
        unique case (r)
            SR_LOW, SR_RSV, SR_OVR: plain_ii = 1'b1;
            SR_EXT, SR_FHI:         plain_ii = odd;
            default:                plain_ii = 1'b0;
        endcase
    endfunction

    assign vg_bad      = (vgein_i == '0) || (vgein_i > GEI_MAX);
    assign m_base_ii   = plain_ii(m_reg_i, m_odd_i);
    assign s_base_ii   = plain_ii(s_reg_i, s_odd_i);
    assign s_file      = (s_reg_i == SR_FLO) || (s_reg_i == SR_FHI);
    assign vs_file     = (vs_reg_i == SR_FLO) || (vs_reg_i == SR_FHI);
    assign vs_file_bad = vs_file && (vg_bad || ((vs_reg_i == SR_FHI) && vs_odd_i));

    always_comb begin
        ii_o = 1'b0;
        vi_o = 1'b0;
        unique case (csr_id_i)
            ID_MWIN: ii_o = m_base_ii;
            ID_SWIN: begin
                if (!virt_i) begin
                    ii_o = s_base_ii || ((priv_i == PRV_S) && seie_virt_i && s_file);
                end else begin
                    ii_o = (vs_reg_i == SR_LOW) || (vs_reg_i == SR_RSV) || (vs_reg_i == SR_OVR);
                    vi_o = (vs_reg_i == SR_EXT) || vs_file_bad;
                end
            end
            ID_VSWIN: ii_o = !vs_file || vs_file_bad;
            default: ;
        endcase
    end
endmodule

// File: rtl/icsr_excp_check.sv
module icsr_excp_check
    import icsr_pkg::*;
#(
    parameter int SEL_W  = 12,
    parameter int VG_W   = 6,
    parameter int GEILEN = 63
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [2:0]       csr_id_i,
    input  logic             wr_i,
    input  logic [1:0]       priv_i,
    input  logic             virt_i,
    input  logic [SEL_W-1:0] msel_i,
    input  logic [SEL_W-1:0] ssel_i,
    input  logic [SEL_W-1:0] vssel_i,
    input  logic [VG_W-1:0]  vgein_i,
    input  logic             seie_virt_i,
    input  logic             vti_i,
    input  logic             base_ill_i,
    input  logic             base_virt_i,
    output logic             ill_o,
    output logic             virt_o
);
    localparam int NWIN = 3;

    logic [SEL_W-1:0] sel_arr [NWIN];
    sel_reg_e         reg_arr [NWIN];
    logic             odd_arr [NWIN];

    assign sel_arr[0] = msel_i;
    assign sel_arr[1] = ssel_i;
    assign sel_arr[2] = vssel_i;

    for (genvar g = 0; g < NWIN; g++) begin : g_cls
        icsr_sel_region #(.SEL_W(SEL_W)) u_cls (
            .sel_i    (sel_arr[g]),
            .region_o (reg_arr[g]),
            .odd_o    (odd_arr[g])
        );
    end

    logic win_ii, win_vi;

    icsr_window_rules #(.GEILEN(GEILEN), .VG_W(VG_W)) u_rules (
        .csr_id_i    (csr_id_i),
        .priv_i      (priv_i),
        .virt_i      (virt_i),
        .seie_virt_i (seie_virt_i),
        .vgein_i     (vgein_i),
        .m_reg_i     (reg_arr[0]),
        .m_odd_i     (odd_arr[0]),
        .s_reg_i     (reg_arr[1]),
        .s_odd_i     (odd_arr[1]),
        .vs_reg_i    (reg_arr[2]),
        .vs_odd_i    (odd_arr[2]),
        .ii_o        (win_ii),
        .vi_o        (win_vi)
    );

    logic guest_s, intr_vi;
    chk_state_t st_d, st_q;

    assign guest_s = virt_i && (priv_i == PRV_S) && vti_i;
    assign intr_vi = guest_s && ((csr_id_i == ID_IPEND) || (csr_id_i == ID_IENAB) ||
                                 ((csr_id_i == ID_TCMP) && wr_i));

    // first step: basic verdict and interrupt rules; second step: select ranges
    always_comb begin
        st_d       = st_q;
        st_d.armed = 1'b1;
        st_d.res   = '0;
        if (base_ill_i)                 st_d.res.ill  = 1'b1;
        else if (base_virt_i || intr_vi) st_d.res.virt = 1'b1;
        else if (win_ii)                st_d.res.ill  = 1'b1;
        else if (win_vi)                st_d.res.virt = 1'b1;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign ill_o  = st_q.res.ill;
    assign virt_o = st_q.res.virt;

    // R10
    excp_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({ill_o, virt_o}));

    // R1
    base_ill_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.armed && $past(base_ill_i)) |-> (ill_o && !virt_o));

    // R2
    base_virt_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.armed && $past(!base_ill_i && base_virt_i)) |-> (virt_o && !ill_o));

    // R7
    vswin_no_virt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.armed && $past(csr_id_i == ID_VSWIN && !base_virt_i && !base_ill_i)) |-> !virt_o);

    // R9
    tcmp_read_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.armed && $past(csr_id_i == ID_TCMP && !wr_i && !base_ill_i && !base_virt_i))
        |-> (!ill_o && !virt_o));

    // R8
    intr_guest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.armed && $past(!base_ill_i && virt_i && priv_i == PRV_S && vti_i &&
                             (csr_id_i == ID_IPEND || csr_id_i == ID_IENAB))) |-> virt_o);

    // R3
    mwin_no_virt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.armed && $past(csr_id_i == ID_MWIN && !base_virt_i)) |-> !virt_o);
endmodule

// File: tb/icsr_excp_check_tb.sv
module icsr_excp_check_tb;
    localparam int CLK_PERIOD = 10;
    localparam int SEL_W  = 12;
    localparam int VG_W   = 6;
    localparam int GEILEN = 5;
    localparam int WD_CYCLES = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] id = '0;
    logic wr = 1'b0;
    logic [1:0] pr = '0;
    logic v = 1'b0;
    logic [SEL_W-1:0] ms = '0, ss = '0, vs = '0;
    logic [VG_W-1:0] vg = '0;
    logic seie = 1'b0, vti = 1'b0, bii = 1'b0, bvi = 1'b0;
    logic ill, virt;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    icsr_excp_check #(.SEL_W(SEL_W), .VG_W(VG_W), .GEILEN(GEILEN)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .csr_id_i(id), .wr_i(wr), .priv_i(pr), .virt_i(v),
        .msel_i(ms), .ssel_i(ss), .vssel_i(vs), .vgein_i(vg), .seie_virt_i(seie),
        .vti_i(vti), .base_ill_i(bii), .base_virt_i(bvi), .ill_o(ill), .virt_o(virt)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc >= WD_CYCLES && !done) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: got running expected finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    function automatic bit old_ii(input int s);
        return (s <= 'h2F) || (s >= 'h30 && s <= 'h3F && s[0]) || (s >= 'h40 && s <= 'h6F) ||
               (s >= 'h80 && s <= 'hFF && s[0]) || (s > 'hFF);
    endfunction

    // returns {illegal, virtual}
    function automatic logic [1:0] model();
        bit bad;
        int s;
        bad = (vg == 0) || (int'(vg) > GEILEN);
        if (bii) return 2'b10;
        if (bvi) return 2'b01;
        if (v && pr == 2'd1 && vti && (id == 3'd4 || id == 3'd5 || (id == 3'd6 && wr))) return 2'b01;
        case (id)
            3'd1: return old_ii(int'(ms)) ? 2'b10 : 2'b00;
            3'd2: begin
                if (!v) begin
                    s = int'(ss);
                    return (old_ii(s) || (pr == 2'd1 && seie && s >= 'h70 && s <= 'hFF)) ? 2'b10 : 2'b00;
                end
                s = int'(vs);
                if (s <= 'h2F || (s >= 'h40 && s <= 'h6F) || s > 'hFF) return 2'b10;
                if (s >= 'h30 && s <= 'h3F) return 2'b01;
                if (s >= 'h70 && (bad || (s > 'h7F && s[0]))) return 2'b01;
                return 2'b00;
            end
            3'd3: begin
                s = int'(vs);
                if (s <= 'h6F || s > 'hFF) return 2'b10;
                if (bad || (s > 'h7F && s[0])) return 2'b10;
                return 2'b00;
            end
            default: return 2'b00;
        endcase
    endfunction

    task automatic chk(input string req, input logic [1:0] exp);
        checks = checks + 1;
        if ({ill, virt} !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: got ill=%0b virt=%0b expected ill=%0b virt=%0b",
                     req, ill, virt, exp[1], exp[0]);
        end
        if (ill === 1'b1 && virt === 1'b1) begin
            errors = errors + 1;
            $display("FAIL R10: got ill=1 virt=1 expected at most one");
        end
    endtask

    // inputs already set at a falling edge; verdict is read one cycle later
    task automatic step(input string req);
        logic [1:0] exp;
        exp = model();
        @(negedge clk);
        chk(req, exp);
    endtask

    task automatic setall(input logic [2:0] i, input logic w, input logic [1:0] p, input logic vv,
                          input logic [5:0] g, input logic se, input logic t,
                          input logic b1, input logic b2);
        id = i; wr = w; pr = p; v = vv; vg = g; seie = se; vti = t; bii = b1; bvi = b2;
    endtask

    initial begin
        // R11: reset holds outputs low even with a raised basic verdict
        @(negedge clk);
        setall(3'd1, 1'b0, 2'd3, 1'b0, 6'd0, 1'b0, 1'b0, 1'b1, 1'b1);
        @(negedge clk);
        chk("R11", 2'b00);
        @(negedge clk);
        chk("R11", 2'b00);
        rst_n = 1'b1;
        step("R1");

        // R3: machine window sweep
        setall(3'd1, 1'b0, 2'd3, 1'b0, 6'd0, 1'b1, 1'b1, 1'b0, 1'b0);
        for (int s = 0; s < 'h200; s++) begin
            ms = SEL_W'(s); ss = ~SEL_W'(s); vs = SEL_W'(s) ^ SEL_W'('h55);
            step("R3");
        end

        // R4: supervisor window, host side, S mode and U mode, both seie values
        for (int k = 0; k < 3; k++) begin
            setall(3'd2, 1'b0, (k == 2) ? 2'd0 : 2'd1, 1'b0, 6'd0, k[0] | (k == 2), 1'b1, 1'b0, 1'b0);
            for (int s = 0; s < 'h200; s++) begin
                ss = SEL_W'(s); ms = ~SEL_W'(s); vs = SEL_W'(s) ^ SEL_W'('h2A);
                step("R4");
            end
        end

        // R5 / R6: supervisor window seen by a guest, several guest index values
        for (int k = 0; k < 4; k++) begin
            setall(3'd2, 1'b0, 2'd1, 1'b1, (k == 0) ? 6'd0 : (k == 1) ? 6'd3 : (k == 2) ? 6'(GEILEN) : 6'(GEILEN + 1),
                   1'b1, 1'b0, 1'b0, 1'b0);
            for (int s = 0; s < 'h200; s++) begin
                vs = SEL_W'(s); ms = ~SEL_W'(s); ss = SEL_W'(s) ^ SEL_W'('h70);
                if (model() == 2'b10) step("R5");
                else                  step("R6");
            end
        end

        // R7: virtual-supervisor window from the host
        for (int k = 0; k < 4; k++) begin
            setall(3'd3, 1'b1, 2'd1, 1'b0, (k == 0) ? 6'd0 : (k == 1) ? 6'd1 : (k == 2) ? 6'(GEILEN) : 6'd63,
                   1'b0, 1'b0, 1'b0, 1'b0);
            for (int s = 0; s < 'h200; s++) begin
                vs = SEL_W'(s); ms = SEL_W'(s) ^ SEL_W'('h81); ss = ~SEL_W'(s);
                step("R7");
            end
        end

        // R2: basic virtual verdict wins over an illegal select value
        setall(3'd3, 1'b0, 2'd1, 1'b1, 6'd0, 1'b0, 1'b0, 1'b0, 1'b1);
        vs = '0;
        step("R2");
        setall(3'd2, 1'b0, 2'd1, 1'b1, 6'd0, 1'b0, 1'b0, 1'b0, 1'b1);
        vs = SEL_W'('h300);
        step("R2");
        // R1: basic illegal verdict wins over the basic virtual one
        setall(3'd4, 1'b0, 2'd1, 1'b1, 6'd0, 1'b0, 1'b1, 1'b1, 1'b1);
        step("R1");

        // R8: interrupt pending/enable over mode, virtualization and trap control
        for (int k = 0; k < 32; k++) begin
            setall(k[0] ? 3'd5 : 3'd4, k[1], k[2] ? 2'd1 : (k[3] ? 2'd3 : 2'd0), k[3], 6'd0,
                   1'b0, k[4], 1'b0, 1'b0);
            step("R8");
        end

        // R9: timer compare, read and write
        for (int k = 0; k < 16; k++) begin
            setall(3'd6, k[0], k[1] ? 2'd1 : 2'd0, k[2], 6'd0, 1'b0, k[3], 1'b0, 1'b0);
            step("R9");
        end

        // R10: unmatched identities stay quiet with every condition raised
        for (int k = 0; k < 2; k++) begin
            setall(k[0] ? 3'd7 : 3'd0, 1'b1, 2'd1, 1'b1, 6'd0, 1'b1, 1'b1, 1'b0, 1'b0);
            ms = '0; ss = '0; vs = '0;
            step("R10");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule